// File: doc/BRIEF.md
# Reversible One-Hot Address Decoder

This block turns an n-bit address into a one-hot select vector of 2^n lines. It is built entirely from reversible primitives, meaning gates with as many outputs as inputs and a one-to-one mapping between input and output patterns. The cheapest address bit is decoded by a two-line controlled-NOT seed whose second input is tied high. That seed yields the address bit and its complement, and it leaves no unused output.

Each higher address bit doubles the set of lines. Every existing line drives its own three-line controlled-swap cell, whose spare input is tied low. The address bit travels through the cells of its stage as the control signal, passing from one cell to the next. The copy of the bit that leaves the final cell of a stage is not used by the decoder. These copies are brought out on a separate garbage port rather than dropped.

The path is purely combinational. The address width is a parameter with supported values 1 to 4. A package provides gate-count and cost figures as functions, so that other logic can use them as constants.

Top module: `revdec_top`

## Requirements
- R1: The controlled-NOT primitive has inputs a, b and outputs p, q with p = a and q = a XOR b.
- R2: The controlled-swap primitive has inputs ctl, din, aux and outputs ctl_o, q0, q1. It sets ctl_o = ctl. When ctl is 0, q0 = din and q1 = aux. When ctl is 1, q0 = aux and q1 = din.
- R3: Each primitive is bijective. All 2^k input patterns of a k-line primitive give pairwise distinct output patterns, where the output pattern is {p,q} or {ctl_o,q0,q1}.
- R4: Bit i of line_sel is 1 exactly when addr equals i, with bit 0 the least significant. The output follows the address in the same cycle.
- R5: Exactly one bit of line_sel is high for every address value, for each address width from 1 to 4.
- R6: For address widths of 2 or more, garbage bit k-1 equals address bit k, for k from 1 to n-1. For width 1 the garbage port is one bit wide and holds 0.
- R7: For width n, the package functions give 2^n − 1 gates, n − 1 garbage lines and a quantum cost of 4·2^n − 7. For n = 2 these are 3 gates, 1 garbage line and a cost of 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | ADDR_W | Address to decode |
| line_sel | output | 2^ADDR_W | One-hot select, bit i high for address i |
| garbage | output | max(1, ADDR_W−1) | Pass-through address copies left over by the expansion stages |

## Verification
The bench builds the decoder at three address widths.

- Width 1 reaches the case with no expansion stage and the tied-zero garbage bit.
- Width 3 exercises two chained stages.
- Width 4 exercises the deepest supported tree: 15 gates and a 16-line output.

Both primitives are also instantiated on their own and driven over every input pattern. This exposes any mapping that merges two input patterns onto one output, which the decoder alone could hide behind its tied ancilla inputs.

// File: rtl/revdec_pkg.sv
package revdec_pkg;

  // Number of reversible gates in an n-bit decoder: seed plus all cells.
  function automatic int gate_total(int n);
    return (1 << n) - 1;
  endfunction

  // Unused pass-through lines: one per expansion stage.
  function automatic int garbage_total(int n);
    return n - 1;
  endfunction

  // Seed cost 1, each swap cell cost 4.
  function automatic int qcost_total(int n);
    return 4 * (1 << n) - 7;
  endfunction

  // Port width of the garbage output; never zero.
  function automatic int garb_port_w(int n);
    return (n > 1) ? n - 1 : 1;
  endfunction

endpackage

// File: rtl/rev_cnot.sv
module rev_cnot (
  input  logic a,
  input  logic b,
  output logic p,
  output logic q
);
  assign p = a;
  assign q = a ^ b;
endmodule

// File: rtl/rev_cswap.sv
module rev_cswap (
  input  logic ctl,
  input  logic din,
  input  logic aux,
  output logic ctl_o,
  output logic q0,
  output logic q1
);
  assign ctl_o = ctl;
  assign q0    = ctl ? aux : din;
  assign q1    = ctl ? din : aux;

  // R2: a swap only moves values, so the number of ones is conserved
  always_comb begin
    if (!$isunknown({ctl, din, aux})) begin
      a_r2_ones_conserved: assert ($countones({ctl, din, aux}) == $countones({ctl_o, q0, q1}))
        else $error("swap cell changed ones count");
    end
  end
endmodule

// File: rtl/rev_expand_stage.sv
module rev_expand_stage #(
  parameter int IN_LINES = 2
) (
  input  logic                  sel,
  input  logic [IN_LINES-1:0]   lines_in,
  output logic [2*IN_LINES-1:0] lines_out,
  output logic                  sel_out
);
  logic [IN_LINES:0] chain;
  assign chain[0] = sel;

  for (genvar j = 0; j < IN_LINES; j++) begin : g_cell
    rev_cswap u_cell (
      .ctl   (chain[j]),
      .din   (lines_in[j]),
      .aux   (1'b0),
      .ctl_o (chain[j+1]),
      .q0    (lines_out[j]),
      .q1    (lines_out[j+IN_LINES])
    );
  end

  assign sel_out = chain[IN_LINES];

  always_comb begin
    if (!$isunknown({sel, lines_in})) begin
      // R5: a one-hot input set stays one-hot after doubling
      a_r5_stage_onehot: assert (!$onehot(lines_in) || $onehot(lines_out))
        else $error("stage broke one-hot");
      // R6: the control copy emerging at the end of the chain equals the address bit
      a_r6_sel_carried: assert (sel_out == sel)
        else $error("control copy corrupted");
    end
  end
endmodule

// File: rtl/revdec_top.sv
module revdec_top #(
  parameter  int ADDR_W = 2,
  localparam int LINES  = 1 << ADDR_W,
  localparam int GARB_W = revdec_pkg::garb_port_w(ADDR_W)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LINES-1:0]  line_sel,
  output logic [GARB_W-1:0] garbage
);
  logic seed_p, seed_q;

  // Seed: b tied high gives {addr[0], ~addr[0]}
  rev_cnot u_seed (
    .a (addr[0]),
    .b (1'b1),
    .p (seed_p),
    .q (seed_q)
  );

  for (genvar k = 1; k < ADDR_W; k++) begin : g_stage
    localparam int IN = 1 << k;
    logic [IN-1:0]   prev;
    logic [2*IN-1:0] nxt;
    logic            sel_left;

    if (k == 1) begin : g_first
      assign prev = {seed_p, seed_q};
    end else begin : g_more
      assign prev = g_stage[k-1].nxt;
    end

    rev_expand_stage #(.IN_LINES(IN)) u_stg (
      .sel       (addr[k]),
      .lines_in  (prev),
      .lines_out (nxt),
      .sel_out   (sel_left)
    );

    assign garbage[k-1] = sel_left;
  end

  if (ADDR_W == 1) begin : g_single
    assign line_sel = {seed_p, seed_q};
    assign garbage  = 1'b0;
  end else begin : g_multi
    assign line_sel = g_stage[ADDR_W-1].nxt;
  end

  always_comb begin
    if (!$isunknown(addr)) begin
      a_r5_single_line: assert ($onehot(line_sel))
        else $error("decoder output not one-hot");
      a_r4_line_at_addr: assert (line_sel[addr] == 1'b1)
        else $error("wrong line selected");
    end
  end

  if (ADDR_W > 1) begin : g_garb_chk
    always_comb begin
      if (!$isunknown(addr)) begin
        a_r6_garbage_tracks: assert (garbage == addr[ADDR_W-1:1])
          else $error("garbage lines do not carry address copies");
      end
    end
  end
endmodule

// File: tb/revdec_top_tb_top.sv
module revdec_top_tb_top;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // Decoder instances at three widths
  logic [2:0]  a3;  logic [7:0]  s3;  logic [1:0] g3;
  logic [0:0]  a1;  logic [1:0]  s1;  logic [0:0] g1;
  logic [3:0]  a4;  logic [15:0] s4;  logic [2:0] g4;

  revdec_top #(.ADDR_W(3)) dut_i    (.addr(a3), .line_sel(s3), .garbage(g3));
  revdec_top #(.ADDR_W(1)) dut_one  (.addr(a1), .line_sel(s1), .garbage(g1));
  revdec_top #(.ADDR_W(4)) dut_four (.addr(a4), .line_sel(s4), .garbage(g4));

  // Stand-alone primitives
  logic cn_a, cn_b, cn_p, cn_q;
  rev_cnot u_cn (.a(cn_a), .b(cn_b), .p(cn_p), .q(cn_q));

  logic cs_c, cs_d, cs_x, cs_co, cs_q0, cs_q1;
  rev_cswap u_cs (.ctl(cs_c), .din(cs_d), .aux(cs_x), .ctl_o(cs_co), .q0(cs_q0), .q1(cs_q1));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_cnot_map;
    logic [3:0] seen = '0;
    for (int v = 0; v < 4; v++) begin
      @(posedge clk);
      cn_a = v[1]; cn_b = v[0];
      @(negedge clk);
      check(cn_p == v[1] && cn_q == (v[1] ^ v[0]), "R1", "cnot mapping",
            {cn_p, cn_q}, {v[1], v[1] ^ v[0]});
      seen[{cn_p, cn_q}] = 1'b1;
    end
    check(seen == 4'hF, "R3", "cnot distinct outputs", seen, 4'hF);
  endtask

  task automatic t_cswap_map;
    logic [7:0] seen = '0;
    for (int v = 0; v < 8; v++) begin
      logic c, d, x, e0, e1;
      c = v[2]; d = v[1]; x = v[0];
      e0 = c ? x : d;
      e1 = c ? d : x;
      @(posedge clk);
      cs_c = c; cs_d = d; cs_x = x;
      @(negedge clk);
      check(cs_co == c && cs_q0 == e0 && cs_q1 == e1, "R2", "swap mapping",
            {cs_co, cs_q0, cs_q1}, {c, e0, e1});
      seen[{cs_co, cs_q0, cs_q1}] = 1'b1;
    end
    check(seen == 8'hFF, "R3", "swap distinct outputs", seen, 8'hFF);
  endtask

  task automatic t_width1;
    for (int v = 0; v < 2; v++) begin
      @(posedge clk);
      a1 = 1'(v);
      @(negedge clk);
      check(s1 == (2'b01 << v), "R4", "width1 select", s1, 2'b01 << v);
      check($countones(s1) == 1, "R5", "width1 one-hot", $countones(s1), 1);
      check(g1 == 1'b0, "R6", "width1 garbage", g1, 0);
    end
  endtask

  task automatic t_width3;
    for (int v = 7; v >= 0; v--) begin
      @(posedge clk);
      a3 = 3'(v);
      @(negedge clk);
      check(s3 == (8'd1 << v), "R4", "width3 select", s3, 8'd1 << v);
      check($countones(s3) == 1, "R5", "width3 one-hot", $countones(s3), 1);
      check(g3 == 2'(v >> 1), "R6", "width3 garbage", g3, v >> 1);
    end
  endtask

  task automatic t_width4;
    for (int v = 0; v < 16; v++) begin
      int w;
      w = (v * 7) % 16;  // scrambled visiting order
      @(posedge clk);
      a4 = 4'(w);
      @(negedge clk);
      check(s4 == (16'd1 << w), "R4", "width4 select", s4, 16'd1 << w);
      check($countones(s4) == 1, "R5", "width4 one-hot", $countones(s4), 1);
      check(g4 == 3'(w >> 1), "R6", "width4 garbage", g4, w >> 1);
    end
  endtask

  task automatic t_costs;
    for (int n = 1; n <= 4; n++) begin
      int gates, cost;
      gates = 1; cost = 1;
      for (int k = 1; k < n; k++) begin
        gates += (1 << k);
        cost  += 4 * (1 << k);
      end
      check(revdec_pkg::gate_total(n) == gates, "R7", "gate count",
            revdec_pkg::gate_total(n), gates);
      check(revdec_pkg::garbage_total(n) == n - 1, "R7", "garbage count",
            revdec_pkg::garbage_total(n), n - 1);
      check(revdec_pkg::qcost_total(n) == cost, "R7", "quantum cost",
            revdec_pkg::qcost_total(n), cost);
    end
    check(revdec_pkg::qcost_total(2) == 9, "R7", "two-bit cost", revdec_pkg::qcost_total(2), 9);
  endtask

  initial begin
    a1 = '0; a3 = '0; a4 = '0;
    cn_a = 1'b0; cn_b = 1'b0;
    cs_c = 1'b0; cs_d = 1'b0; cs_x = 1'b0;
    repeat (2) @(posedge clk);
    t_cnot_map();
    t_cswap_map();
    t_width1();
    t_width3();
    t_width4();
    t_costs();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule